// File: doc/BRIEF.md
# Periodic Split-Transaction Microframe Selector

This block sits inside the periodic schedule walker of a USB 2.0 host controller. For each queue head the walker presents, it decides whether that entry may run in the current microframe and, if so, which kind of transaction to run. It picks one bit out of each of two per-microframe bitmasks, using the low three bits of the frame index. The interrupt schedule mask gates regular transactions and start-splits. The split completion mask gates complete-splits.

High-speed endpoints get a plain transaction, with the direction taken from the token PID. Full-speed and low-speed endpoints behind a hub alternate between a start phase and a complete phase. The block drives the hub address and hub port fields out alongside each split strobe. It also returns the updated phase bit, so the walker can write it back to the entry.

The block evaluates once per microframe tick. Every result is registered and appears on the outputs in the cycle after the tick. It also checks the mask configuration, and reports entries whose masks are illegal.

Top module: `uframe_split_sel`

## Requirements
- R1: Inputs are evaluated only in a cycle with `tick` high, and the results appear on the outputs in the following cycle. In any cycle not preceded by a tick, the strobes and `cfg_err` are 0, while `hub_addr`, `hub_port` and `split_state_next` hold their values. Reset drives every output to 0.
- R2: Frame index value n selects bit n of the S-mask (`ep_caps[7:0]`) and bit n of the C-mask (`ep_caps[15:8]`). Bit 0 is the first microframe.
- R3: A high-speed entry (`ep_speed`=2'b10) that is active, on the periodic list (`on_periodic`=1) and has its indexed S-mask bit set raises `hs_xact` and `candidate`. `hs_dir_in` is 1 when `tok_pid` is 2'b01 (IN), and 0 for any other PID.
- R4: A full-speed (2'b00) or low-speed (2'b01) entry that is active, periodic, in the start phase (`split_state`=0) and has its indexed S-mask bit set raises `start_split` and `candidate`.
- R5: The same kind of entry, in the complete phase (`split_state`=1) with its indexed C-mask bit set, raises `complete_split` and `candidate`. An S-mask hit in the complete phase issues nothing.
- R6: The C-mask is ignored for high-speed entries and for entries on the asynchronous list. It causes no complete-split and no C-mask error for them.
- R7: `cfg_err[0]` is set when a full- or low-speed periodic entry has a C-mask of zero. No complete-split is then issued.
- R8: `cfg_err[1]` is set when a full- or low-speed periodic entry has a C-mask bit and an S-mask bit set at the same position.
- R9: `cfg_err[2]` is set when an entry on the asynchronous list has a non-zero S-mask. Asynchronous entries never raise a strobe.
- R10: With `active`=0, no strobe is raised, but `cfg_err` is still reported.
- R11: Speed code 2'b11 is reserved and never raises a strobe.
- R12: `hub_addr` carries `ep_caps[22:16]` and `hub_port` carries `ep_caps[29:23]` in a result cycle that has a start-split or complete-split. In any other result cycle both are 0.
- R13: `split_state_next` is 1 after a start-split, 0 after a complete-split with `cs_done`=1, and otherwise equals `split_state`.
- R14: Masks with several bits set make the entry eligible in every microframe whose bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Evaluate the presented entry in this cycle |
| uframe_idx | input | 3 | Low three bits of the frame index |
| ep_caps | input | 30 | Capabilities word: S-mask, C-mask, hub address, hub port |
| ep_speed | input | 2 | Endpoint speed code |
| on_periodic | input | 1 | 1 when the entry is on the periodic list |
| active | input | 1 | Entry Active bit |
| split_state | input | 1 | Split phase: 0 start, 1 complete |
| cs_done | input | 1 | The complete-split issued now finishes the split |
| tok_pid | input | 2 | Token PID code of a high-speed entry |
| candidate | output | 1 | Entry runs a transaction this microframe |
| start_split | output | 1 | Issue a start-split |
| complete_split | output | 1 | Issue a complete-split |
| hs_xact | output | 1 | Issue a high-speed transaction |
| hs_dir_in | output | 1 | High-speed transaction is IN |
| hub_addr | output | 7 | Hub device address for split tokens |
| hub_port | output | 7 | Hub port number for split tokens |
| split_state_next | output | 1 | Updated split phase bit |
| cfg_err | output | 3 | Bit 0 C-mask zero, bit 1 mask overlap, bit 2 async S-mask set |

## Verification
The bench sweeps one entry across all eight microframes in both split phases. A design that indexed the masks from the wrong end, or that ignored the phase bit, would issue start-splits and complete-splits in the wrong slots. Directed vectors feed a zero C-mask, an overlapping mask pair and an asynchronous entry with an interrupt mask. A design that skipped these checks would either leave `cfg_err` silent or let a complete-split escape. Further cases aim a C-mask hit at a high-speed entry, present the reserved speed code, and clear the Active bit; these catch designs that apply split rules too widely or ignore Active. Cycles without a tick are checked to show that strobes fall back to zero while the hub fields hold.

// File: rtl/usel_pkg.sv
package usel_pkg;

    localparam int UF_W   = 3;
    localparam int NUM_UF = 1 << UF_W;
    localparam int ADDR_W = 7;
    localparam int CAPS_W = 2 * NUM_UF + 2 * ADDR_W;
    localparam int ERR_W  = 3;

    localparam int ERR_CZERO = 0;
    localparam int ERR_OVLP  = 1;
    localparam int ERR_ASYNC = 2;

    typedef enum logic [1:0] {
        SPD_FULL = 2'b00,
        SPD_LOW  = 2'b01,
        SPD_HIGH = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        PID_OUT   = 2'b00,
        PID_IN    = 2'b01,
        PID_SETUP = 2'b10,
        PID_RSV   = 2'b11
    } pid_e;

    typedef struct packed {
        logic [ADDR_W-1:0] port;
        logic [ADDR_W-1:0] hub;
        logic [NUM_UF-1:0] cmask;
        logic [NUM_UF-1:0] smask;
    } caps_t;

    typedef struct packed {
        logic              s_hit;
        logic              c_hit;
        logic              s_any;
        logic              c_any;
        logic              overlap;
    } hits_t;

    typedef struct packed {
        logic              cand;
        logic              ss;
        logic              cs;
        logic              hs;
        logic              dir_in;
        logic [ADDR_W-1:0] hub;
        logic [ADDR_W-1:0] port;
        logic              ss_next;
        logic [ERR_W-1:0]  err;
    } result_t;

    function automatic logic speed_is_split(speed_e s);
        return (s == SPD_FULL) || (s == SPD_LOW);
    endfunction

endpackage

// File: rtl/usel_mask_pick.sv
module usel_mask_pick #(
    parameter int UF_W = usel_pkg::UF_W,
    localparam int NUF = 1 << UF_W
) (
    input  logic [UF_W-1:0] idx,
    input  logic [NUF-1:0]  smask,
    input  logic [NUF-1:0]  cmask,
    output usel_pkg::hits_t hits
);
    logic [NUF-1:0] sel;

    // one-hot decode of the microframe slot
    for (genvar i = 0; i < NUF; i++) begin : g_sel
        assign sel[i] = (idx == UF_W'(i));
    end

    always_comb begin
        hits.s_hit   = |(sel & smask);
        hits.c_hit   = |(sel & cmask);
        hits.s_any   = |smask;
        hits.c_any   = |cmask;
        hits.overlap = |(smask & cmask);
    end
endmodule

// File: rtl/usel_rule.sv
module usel_rule
    import usel_pkg::*;
(
    input  speed_e            speed,
    input  logic              periodic,
    input  logic              active,
    input  logic              split_state,
    input  logic              cs_done,
    input  pid_e              pid,
    input  hits_t             hits,
    input  logic [ADDR_W-1:0] hub,
    input  logic [ADDR_W-1:0] port,
    output result_t           res
);
    logic split_ep;
    logic use_c;
    logic go;

    always_comb begin
        split_ep = speed_is_split(speed);
        use_c    = split_ep && periodic;
        go       = active && periodic;

        res = '0;
        res.err[ERR_CZERO] = use_c && !hits.c_any;
        res.err[ERR_OVLP]  = use_c && hits.overlap;
        res.err[ERR_ASYNC] = !periodic && hits.s_any;

        res.hs = go && (speed == SPD_HIGH) && hits.s_hit;
        res.ss = go && split_ep && !split_state && hits.s_hit;
        res.cs = go && split_ep && split_state && hits.c_hit && hits.c_any;

        res.dir_in = res.hs && (pid == PID_IN);
        res.cand   = res.hs || res.ss || res.cs;

        if (res.ss || res.cs) begin
            res.hub  = hub;
            res.port = port;
        end

        if (res.ss)
            res.ss_next = 1'b1;
        else if (res.cs && cs_done)
            res.ss_next = 1'b0;
        else
            res.ss_next = split_state;
    end
endmodule

// File: rtl/usel_out_reg.sv
module usel_out_reg
    import usel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  result_t nxt,
    output result_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (tick) begin
            q <= nxt;
        end else begin
            q.cand   <= 1'b0;
            q.ss     <= 1'b0;
            q.cs     <= 1'b0;
            q.hs     <= 1'b0;
            q.dir_in <= 1'b0;
            q.err    <= '0;
        end
    end
endmodule

// File: rtl/uframe_split_sel.sv
module uframe_split_sel
    import usel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [UF_W-1:0]     uframe_idx,
    input  logic [CAPS_W-1:0]   ep_caps,
    input  logic [1:0]          ep_speed,
    input  logic                on_periodic,
    input  logic                active,
    input  logic                split_state,
    input  logic                cs_done,
    input  logic [1:0]          tok_pid,
    output logic                candidate,
    output logic                start_split,
    output logic                complete_split,
    output logic                hs_xact,
    output logic                hs_dir_in,
    output logic [ADDR_W-1:0]   hub_addr,
    output logic [ADDR_W-1:0]   hub_port,
    output logic                split_state_next,
    output logic [ERR_W-1:0]    cfg_err
);
    caps_t   caps;
    hits_t   hits;
    result_t res_d;
    result_t res_q;

    assign caps = caps_t'(ep_caps);

    usel_mask_pick #(.UF_W(UF_W)) u_pick (
        .idx   (uframe_idx),
        .smask (caps.smask),
        .cmask (caps.cmask),
        .hits  (hits)
    );

    usel_rule u_rule (
        .speed       (speed_e'(ep_speed)),
        .periodic    (on_periodic),
        .active      (active),
        .split_state (split_state),
        .cs_done     (cs_done),
        .pid         (pid_e'(tok_pid)),
        .hits        (hits),
        .hub         (caps.hub),
        .port        (caps.port),
        .res         (res_d)
    );

    usel_out_reg u_oreg (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .nxt  (res_d),
        .q    (res_q)
    );

    assign candidate        = res_q.cand;
    assign start_split      = res_q.ss;
    assign complete_split   = res_q.cs;
    assign hs_xact          = res_q.hs;
    assign hs_dir_in        = res_q.dir_in;
    assign hub_addr         = res_q.hub;
    assign hub_port         = res_q.port;
    assign split_state_next = res_q.ss_next;
    assign cfg_err          = res_q.err;
endmodule

// File: rtl/uframe_split_sel_chk.sv
module uframe_split_sel_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic [2:0]  uframe_idx,
    input logic [29:0] ep_caps,
    input logic [1:0]  ep_speed,
    input logic        on_periodic,
    input logic        active,
    input logic        split_state,
    input logic        cs_done,
    input logic [1:0]  tok_pid,
    input logic        candidate,
    input logic        start_split,
    input logic        complete_split,
    input logic        hs_xact,
    input logic        hs_dir_in,
    input logic [6:0]  hub_addr,
    input logic [6:0]  hub_port,
    input logic        split_state_next,
    input logic [2:0]  cfg_err
);
    logic started;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    // R1: strobes fall back to zero between ticks
    a_r1_quiet_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(tick)) |-> !(start_split || complete_split || hs_xact || cfg_err != 3'b000));

    // R10: inactive entries raise no strobe
    a_r10_inactive_silent: assert property (@(posedge clk) disable iff (rst)
        (started && $past(tick) && !$past(active)) |-> !(start_split || complete_split || hs_xact));

    // R11: reserved speed raises no strobe
    a_r11_reserved_speed: assert property (@(posedge clk) disable iff (rst)
        (started && $past(tick) && $past(ep_speed) == 2'b11) |-> !(start_split || complete_split || hs_xact));

    // R5: a complete-split needs the indexed C-mask bit
    a_r5_cs_needs_cbit: assert property (@(posedge clk) disable iff (rst)
        (started && complete_split) |-> ((($past(ep_caps[15:8]) >> $past(uframe_idx)) & 8'h01) == 8'h01));

    // R7: zero C-mask never yields a complete-split
    a_r7_czero_no_cs: assert property (@(posedge clk) disable iff (rst)
        (started && $past(tick) && $past(ep_caps[15:8]) == 8'h00) |-> !complete_split);

    // R9: asynchronous entries raise no strobe
    a_r9_async_silent: assert property (@(posedge clk) disable iff (rst)
        (started && $past(tick) && !$past(on_periodic)) |-> !(start_split || complete_split || hs_xact));

    // R4: at most one kind of transaction, and candidate tracks it
    a_r4_one_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_split, complete_split, hs_xact}) && (candidate == (start_split || complete_split || hs_xact)));

    // R13: a start-split moves the phase to complete
    a_r13_ss_sets_phase: assert property (@(posedge clk) disable iff (rst)
        start_split |-> split_state_next);
endmodule

bind uframe_split_sel uframe_split_sel_chk u_chk (.*);

// File: tb/uframe_split_sel_tb.sv
module uframe_split_sel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [2:0]  uframe_idx;
    logic [29:0] ep_caps;
    logic [1:0]  ep_speed;
    logic        on_periodic;
    logic        active;
    logic        split_state;
    logic        cs_done;
    logic [1:0]  tok_pid;
    logic        candidate, start_split, complete_split, hs_xact, hs_dir_in;
    logic [6:0]  hub_addr, hub_port;
    logic        split_state_next;
    logic [2:0]  cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uframe_split_sel u_dut (
        .clk, .rst, .tick, .uframe_idx, .ep_caps, .ep_speed, .on_periodic,
        .active, .split_state, .cs_done, .tok_pid, .candidate, .start_split,
        .complete_split, .hs_xact, .hs_dir_in, .hub_addr, .hub_port,
        .split_state_next, .cfg_err
    );

    typedef struct packed {
        logic [2:0]  idx;
        logic [29:0] caps;
        logic [1:0]  spd;
        logic        per;
        logic        act;
        logic        sst;
        logic        csd;
        logic [1:0]  pid;
        logic [4:0]  req;
        logic [22:0] exp;   // cand,ss,cs,hs,dir,hub,port,ssn,err
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 30'h01950002, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 5'd3,  {5'b10011, 7'h00, 7'h00, 1'b0, 3'b000}}, // R3
        '{3'd1, 30'h01950002, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 5'd3,  {5'b10010, 7'h00, 7'h00, 1'b0, 3'b000}}, // R3
        '{3'd0, 30'h01950002, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 5'd2,  {5'b00000, 7'h00, 7'h00, 1'b0, 3'b000}}, // R2
        '{3'd2, 30'h01953804, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 5'd4,  {5'b11000, 7'h15, 7'h03, 1'b1, 3'b000}}, // R4 R12
        '{3'd4, 30'h01953804, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 5'd5,  {5'b10100, 7'h15, 7'h03, 1'b1, 3'b000}}, // R5
        '{3'd5, 30'h01953804, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 5'd13, {5'b10100, 7'h15, 7'h03, 1'b0, 3'b000}}, // R13
        '{3'd2, 30'h01953804, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 5'd5,  {5'b00000, 7'h00, 7'h00, 1'b1, 3'b000}}, // R5
        '{3'd2, 30'h01950004, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 5'd7,  {5'b00000, 7'h00, 7'h00, 1'b1, 3'b001}}, // R7
        '{3'd2, 30'h01950C04, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 5'd8,  {5'b11000, 7'h15, 7'h03, 1'b1, 3'b010}}, // R8
        '{3'd1, 30'h01950002, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 5'd9,  {5'b00000, 7'h00, 7'h00, 1'b0, 3'b100}}, // R9
        '{3'd0, 30'h01950000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 5'd6,  {5'b00000, 7'h00, 7'h00, 1'b0, 3'b000}}, // R6
        '{3'd2, 30'h01950004, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 5'd10, {5'b00000, 7'h00, 7'h00, 1'b1, 3'b001}}, // R10
        '{3'd1, 30'h01950002, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 5'd11, {5'b00000, 7'h00, 7'h00, 1'b0, 3'b000}}, // R11
        '{3'd2, 30'h01950400, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 5'd6,  {5'b00000, 7'h00, 7'h00, 1'b1, 3'b000}}, // R6
        '{3'd2, 30'h01953804, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 5'd9,  {5'b00000, 7'h00, 7'h00, 1'b0, 3'b100}}  // R9
    };

    function automatic logic [22:0] got_bits();
        return {candidate, start_split, complete_split, hs_xact, hs_dir_in,
                hub_addr, hub_port, split_state_next, cfg_err};
    endfunction

    task automatic check(input string tag, input logic [22:0] act_v, input logic [22:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic apply(input logic [2:0] idx, input logic [29:0] caps, input logic [1:0] spd,
                         input logic per, input logic act, input logic sst, input logic csd,
                         input logic [1:0] pid);
        @(negedge clk);
        uframe_idx = idx; ep_caps = caps; ep_speed = spd; on_periodic = per;
        active = act; split_state = sst; cs_done = csd; tok_pid = pid; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; uframe_idx = '0; ep_caps = '0; ep_speed = '0;
        on_periodic = 1'b0; active = 1'b0; split_state = 1'b0; cs_done = 1'b0; tok_pid = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", got_bits(), 23'h0);
        rst = 1'b0;

        // table walk
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].idx, VECS[v].caps, VECS[v].spd, VECS[v].per, VECS[v].act,
                  VECS[v].sst, VECS[v].csd, VECS[v].pid);
            check($sformatf("R%0d vec%0d", VECS[v].req, v), got_bits(), VECS[v].exp);
        end

        // R1: after a start-split, a cycle without tick clears strobes, holds hub fields
        apply(3'd2, 30'h01953804, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
        @(negedge clk);
        check("R1 no tick", got_bits(), {5'b00000, 7'h15, 7'h03, 1'b1, 3'b000});

        // R14 sweep: S-mask 0x05, C-mask 0x70, full speed, both phases
        for (int ph = 0; ph < 2; ph++) begin
            for (int u = 0; u < 8; u++) begin
                logic s_e, c_e, k_ss, k_cs;
                s_e  = (u == 0) || (u == 2);
                c_e  = (u >= 4) && (u <= 6);
                k_ss = (ph == 0) && s_e;
                k_cs = (ph == 1) && c_e;
                apply(3'(u), 30'h01957005, 2'b00, 1'b1, 1'b1, ph[0], 1'b0, 2'b00);
                check($sformatf("R14 ph%0d uf%0d", ph, u), got_bits(),
                      {k_ss || k_cs, k_ss, k_cs, 2'b00,
                       (k_ss || k_cs) ? 7'h15 : 7'h00,
                       (k_ss || k_cs) ? 7'h03 : 7'h00,
                       k_ss ? 1'b1 : ph[0], 3'b000});
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule